// File: doc/BRIEF.md
# USB Interrupt Status Aggregator

This block collects the event sources of a USB device or host controller into eight sticky status bits. It gates them with a matching enable register and drives a single registered interrupt request.

Two of the sources are timed inside the block from a synchronized two-bit line-state input:
- **Sleep** fires after a long unbroken idle stretch.
- **Bus reset** fires after a sustained single-ended-zero condition. It re-arms only after the line leaves that state.

The remaining sources arrive as one-cycle pulses or level flags from neighbouring logic:
- token completion;
- start-of-frame;
- stall;
- attach;
- resume;
- a vector of error flags.

In host mode, start-of-frame is instead derived from a frame-time countdown reaching a programmable threshold.

Token completion also carries a status byte. The block keeps one visible token-status register and one holding slot behind it. Acknowledging the token-done bit promotes the held entry. If no entry is held, the acknowledge clears the register. A token that finds both places occupied sets a sticky overflow flag and is dropped.

Software reaches status, enable, token status, the frame threshold and the overflow flag through a small synchronous write / combinational read port.

Top module: `usb_irq_hub`

## Requirements
- R1: After reset every register reads 0x00 and `irq` is low: status, enable, token status, threshold and overflow.
- R2: `line_state` encodes 00 = SE0, 01 = J, 10 = K, 11 = SE1. Status bit 4 (sleep) sets after IDLE_CYC = CLK_HZ*3/1000 consecutive clock cycles of J. It sets only once per unbroken idle stretch, and any non-J cycle restarts the count.
- R3: Status bit 0 (bus reset) sets after RST_CYC = CLK_HZ/400000 consecutive cycles of SE0. It does not set again until the line has left SE0 and then held SE0 for RST_CYC cycles once more.
- R4: Status bit 1 (error) sets in any cycle where at least one bit of `err_flags` is high.
- R5: Status bit 2 (start-of-frame) behaves differently by mode:
  - With `host_mode` low, it sets on `sof_rx`.
  - With `host_mode` high, it sets once each time `frame_remain` arrives at the threshold register (address 3). In host mode `sof_rx` is not used.
- R6: Three pulse inputs set their own status bits: bit 7 from `stall_evt`, bit 6 from `attach_evt`, and bit 5 from `resume_evt`.
- R7: Status (address 0) is write-one-to-clear. Writing 0 to a bit leaves it unchanged, and a set event in the same cycle as a clearing write wins.
- R8: Token handling works as follows:
  - If `tok_done` arrives while status bit 3 is clear, it loads `tok_in` into token status (address 2) and sets bit 3.
  - If bit 3 is already set, the byte waits in the holding slot.
  - Writing 1 to bit 3 with an entry held moves that entry into token status, and bit 3 stays set.
  - With no entry held, the same write clears both token status and bit 3.
- R9: A `tok_done` that arrives while bit 3 is set and the holding slot is full is dropped. It also sets bit 0 of address 4, which stays set until a 1 is written to that bit.
- R10: Enable (address 1) is read/write, and `irq` is the OR over all eight bits of (status AND enable). `irq` changes on the same clock edge as the status or enable value that causes the change.
- R11: `reg_rdata` reflects `reg_addr` combinationally. Addresses 5 to 7 read 0, and writes to token status (address 2) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_state | input | 2 | Synchronized bus line state (00 SE0, 01 J, 10 K, 11 SE1) |
| host_mode | input | 1 | 1 selects host-mode start-of-frame source |
| sof_rx | input | 1 | Pulse: start-of-frame token received (device mode) |
| frame_remain | input | FRAME_W | Remaining frame time from the host frame counter |
| tok_done | input | 1 | Pulse: a token transaction completed |
| tok_in | input | 8 | Status byte belonging to the completed token |
| stall_evt | input | 1 | Pulse: stall handshake event |
| attach_evt | input | 1 | Pulse: device attach event |
| resume_evt | input | 1 | Pulse: resume signalling seen |
| err_flags | input | ERR_W | Error source flags |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq | output | 1 | Interrupt request |

## Verification
Each fault in an internal counter or slot shows up at the ports at a predictable time:
- An idle or reset counter that is off by one moves the status bit by one cycle. The bench therefore samples the cycle before and the cycle of the threshold.
- A reset detector that fails to re-arm shows as a second, unwanted status set while SE0 is held after a clear.
- A holding slot that loses or duplicates an entry is caught by the very next acknowledge, which reads back the wrong token byte or leaves bit 3 in the wrong state.
- A stale enable or status term appears on `irq` in the same cycle as the register change, because `irq` is computed from next-state values.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } line_e;

    // status / enable bit positions
    localparam int B_BRST = 0;
    localparam int B_ERR  = 1;
    localparam int B_SOF  = 2;
    localparam int B_TOK  = 3;
    localparam int B_SLP  = 4;
    localparam int B_RSM  = 5;
    localparam int B_ATT  = 6;
    localparam int B_STL  = 7;

    localparam logic [ADDR_W-1:0] A_STAT = 3'd0;
    localparam logic [ADDR_W-1:0] A_EN   = 3'd1;
    localparam logic [ADDR_W-1:0] A_TOK  = 3'd2;
    localparam logic [ADDR_W-1:0] A_THR  = 3'd3;
    localparam logic [ADDR_W-1:0] A_OVF  = 3'd4;

    typedef struct packed {
        logic [REG_W-1:0] stat;
        logic [REG_W-1:0] en;
        logic [REG_W-1:0] thr;
        logic             ovf;
        logic             irq;
    } hub_regs_t;

    typedef struct packed {
        logic [REG_W-1:0] cur;
        logic [REG_W-1:0] hold;
        logic             hv;
    } tok_regs_t;

endpackage

// File: rtl/usb_run_timer.sv
module usb_run_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    output logic fire
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] CNT_TOP  = CW'(LIMIT);
    localparam logic [CW-1:0] CNT_LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        fire  = match && (cnt_q == CNT_LAST);
        cnt_d = cnt_q;
        if (!match)
            cnt_d = '0;
        else if (cnt_q != CNT_TOP)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end
endmodule

// File: rtl/usb_sof_gen.sv
module usb_sof_gen
    import usb_irq_pkg::*;
#(
    parameter int FRAME_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_mode,
    input  logic               sof_rx,
    input  logic [FRAME_W-1:0] frame_remain,
    input  logic [REG_W-1:0]   thr,
    output logic               evt
);
    logic hit_d, hit_q;
    logic at_thr;

    always_comb begin
        at_thr = (frame_remain == FRAME_W'(thr));
        hit_d  = at_thr;
        evt    = host_mode ? (at_thr && !hit_q) : sof_rx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hit_q <= 1'b0;
        else
            hit_q <= hit_d;
    end
endmodule

// File: rtl/usb_tok_slot.sv
module usb_tok_slot
    import usb_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic [REG_W-1:0] tok_in,
    input  logic             ack,
    input  logic             flag_q,
    output logic             flag_d,
    output logic [REG_W-1:0] cur,
    output logic             hold_v,
    output logic             ovf_evt
);
    tok_regs_t q, d;

    always_comb begin
        d       = q;
        flag_d  = flag_q;
        ovf_evt = 1'b0;
        // acknowledge is applied before a same-cycle completion
        if (ack && flag_q) begin
            if (q.hv) begin
                d.cur  = q.hold;
                d.hv   = 1'b0;
                flag_d = 1'b1;
            end else begin
                d.cur  = '0;
                flag_d = 1'b0;
            end
        end
        if (evt) begin
            if (!flag_d) begin
                d.cur  = tok_in;
                flag_d = 1'b1;
            end else if (!d.hv) begin
                d.hold = tok_in;
                d.hv   = 1'b1;
            end else begin
                ovf_evt = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign cur    = q.cur;
    assign hold_v = q.hv;
endmodule

// File: rtl/usb_irq_hub.sv
module usb_irq_hub
    import usb_irq_pkg::*;
#(
    parameter int CLK_HZ  = 48_000_000,
    parameter int ERR_W   = 8,
    parameter int FRAME_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         line_state,
    input  logic               host_mode,
    input  logic               sof_rx,
    input  logic [FRAME_W-1:0] frame_remain,
    input  logic               tok_done,
    input  logic [7:0]         tok_in,
    input  logic               stall_evt,
    input  logic               attach_evt,
    input  logic               resume_evt,
    input  logic [ERR_W-1:0]   err_flags,
    input  logic               reg_wr,
    input  logic [2:0]         reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    output logic               irq
);
    localparam int IDLE_RAW = (CLK_HZ * 3) / 1000;
    localparam int RST_RAW  = CLK_HZ / 400000;
    localparam int IDLE_CYC = (IDLE_RAW < 1) ? 1 : IDLE_RAW;
    localparam int RST_CYC  = (RST_RAW < 1) ? 1 : RST_RAW;

    hub_regs_t q, d;

    logic idle_fire, brst_fire, sof_evt;
    logic tok_flag_d, tok_hold_v, tok_ovf;
    logic [REG_W-1:0] tok_cur;
    logic wr_stat, wr_en, wr_thr, wr_ovf;

    // Views for the bound checker
    logic [REG_W-1:0] stat_view, en_view;
    logic             ovf_view;

    assign wr_stat = reg_wr && (reg_addr == A_STAT);
    assign wr_en   = reg_wr && (reg_addr == A_EN);
    assign wr_thr  = reg_wr && (reg_addr == A_THR);
    assign wr_ovf  = reg_wr && (reg_addr == A_OVF);

    usb_run_timer #(.LIMIT(IDLE_CYC)) u_idle (
        .clk   (clk),
        .rst_n (rst_n),
        .match (line_state == LS_J),
        .fire  (idle_fire)
    );

    usb_run_timer #(.LIMIT(RST_CYC)) u_brst (
        .clk   (clk),
        .rst_n (rst_n),
        .match (line_state == LS_SE0),
        .fire  (brst_fire)
    );

    usb_sof_gen #(.FRAME_W(FRAME_W)) u_sof (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_mode    (host_mode),
        .sof_rx       (sof_rx),
        .frame_remain (frame_remain),
        .thr          (q.thr),
        .evt          (sof_evt)
    );

    usb_tok_slot u_tok (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt     (tok_done),
        .tok_in  (tok_in),
        .ack     (wr_stat && reg_wdata[B_TOK]),
        .flag_q  (q.stat[B_TOK]),
        .flag_d  (tok_flag_d),
        .cur     (tok_cur),
        .hold_v  (tok_hold_v),
        .ovf_evt (tok_ovf)
    );

    logic [REG_W-1:0] set_vec, clr_vec;

    always_comb begin
        set_vec         = '0;
        set_vec[B_BRST] = brst_fire;
        set_vec[B_ERR]  = |err_flags;
        set_vec[B_SOF]  = sof_evt;
        set_vec[B_SLP]  = idle_fire;
        set_vec[B_RSM]  = resume_evt;
        set_vec[B_ATT]  = attach_evt;
        set_vec[B_STL]  = stall_evt;
        clr_vec         = wr_stat ? reg_wdata : '0;

        d             = q;
        d.stat        = (q.stat & ~clr_vec) | set_vec;
        d.stat[B_TOK] = tok_flag_d;
        if (wr_en)
            d.en = reg_wdata;
        if (wr_thr)
            d.thr = reg_wdata;
        d.ovf = (q.ovf && !(wr_ovf && reg_wdata[0])) || tok_ovf;
        d.irq = |(d.stat & d.en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    always_comb begin
        case (reg_addr)
            A_STAT:  reg_rdata = q.stat;
            A_EN:    reg_rdata = q.en;
            A_TOK:   reg_rdata = tok_cur;
            A_THR:   reg_rdata = q.thr;
            A_OVF:   reg_rdata = {7'd0, q.ovf};
            default: reg_rdata = '0;
        endcase
    end

    assign irq       = q.irq;
    assign stat_view = q.stat;
    assign en_view   = q.en;
    assign ovf_view  = q.ovf;
endmodule

// File: rtl/usb_irq_hub_chk.sv
module usb_irq_hub_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] line_state,
    input logic       reg_wr,
    input logic [2:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic       tok_done,
    input logic [7:0] stat,
    input logic [7:0] en,
    input logic       ovf,
    input logic       hold_v,
    input logic       irq
);
    // R10
    irq_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == |(stat & en));

    // R3
    brst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[0]) |-> $past(line_state) == 2'b00);

    // R2
    sleep_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[4]) |-> $past(line_state) == 2'b01);

    // R8
    tok_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd0 && reg_wdata[3] && stat[3] && !hold_v && !tok_done)
        |=> !stat[3]);

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(reg_wr && reg_addr == 3'd4 && reg_wdata[0])) |=> ovf);

    // R10
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == 3'd1) |=> $stable(en));
endmodule

bind usb_irq_hub usb_irq_hub_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_state (line_state),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .tok_done   (tok_done),
    .stat       (stat_view),
    .en         (en_view),
    .ovf        (ovf_view),
    .hold_v     (tok_hold_v),
    .irq        (irq)
);

// File: tb/usb_irq_hub_test.sv
module usb_irq_hub_test;
    localparam int HZ    = 4_000_000;
    localparam int IDLE  = HZ * 3 / 1000;
    localparam int RSTC  = HZ / 400000;
    localparam int ERR_W = 8;
    localparam int FW    = 14;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      line_state = 2'b10;
    logic            host_mode = 1'b0;
    logic            sof_rx = 1'b0;
    logic [FW-1:0]   frame_remain = '0;
    logic            tok_done = 1'b0;
    logic [7:0]      tok_in = '0;
    logic            stall_evt = 1'b0;
    logic            attach_evt = 1'b0;
    logic            resume_evt = 1'b0;
    logic [ERR_W-1:0] err_flags = '0;
    logic            reg_wr = 1'b0;
    logic [2:0]      reg_addr = '0;
    logic [7:0]      reg_wdata = '0;
    logic [7:0]      reg_rdata;
    logic            irq;

    int total = 0;
    int fails = 0;

    always #10 clk = ~clk;

    usb_irq_hub #(.CLK_HZ(HZ), .ERR_W(ERR_W), .FRAME_W(FW)) uut (
        .clk(clk), .rst_n(rst_n), .line_state(line_state), .host_mode(host_mode),
        .sof_rx(sof_rx), .frame_remain(frame_remain), .tok_done(tok_done),
        .tok_in(tok_in), .stall_evt(stall_evt), .attach_evt(attach_evt),
        .resume_evt(resume_evt), .err_flags(err_flags), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        tick();
        reg_wr = 1'b0;
    endtask

    function automatic logic [7:0] next_stat(input logic [7:0] s, input logic [7:0] clr,
                                             input logic [7:0] set);
        return (s & ~clr) | set;
    endfunction

    initial begin
        #(20 * 190000);
        fails++;
        total++;
        $display("FAIL watchdog: run did not complete");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] m_stat, m_en, clr, set;
        void'($urandom(32'd20240611));
        ticks(3);
        rst_n = 1'b1;
        tick();

        // R1 reset values
        for (int a = 0; a < 5; a++) begin
            rd(3'(a), v);
            check("R1 reset reg", v, 0);
        end
        check("R1 irq reset", irq, 0);

        // R11 unused addresses and read-only token status
        rd(3'd5, v); check("R11 addr5", v, 0);
        rd(3'd7, v); check("R11 addr7", v, 0);
        wr(3'd2, 8'hAA);
        rd(3'd2, v); check("R11 tok ro", v, 0);
        wr(3'd3, 8'h5A);
        rd(3'd3, v); check("R11 thr rw", v, 8'h5A);

        // R2 sleep after IDLE consecutive J cycles
        line_state = 2'b01;
        ticks(IDLE - 1);
        rd(3'd0, v); check("R2 sleep early", v[4], 0);
        tick();
        rd(3'd0, v); check("R2 sleep set", v[4], 1);
        wr(3'd0, 8'h10);
        ticks(20);
        rd(3'd0, v); check("R2 sleep once", v[4], 0);
        line_state = 2'b10;
        tick();

        // R3 bus reset after RSTC SE0 cycles, re-arm after release
        line_state = 2'b00;
        ticks(RSTC - 1);
        rd(3'd0, v); check("R3 brst early", v[0], 0);
        tick();
        rd(3'd0, v); check("R3 brst set", v[0], 1);
        wr(3'd0, 8'h01);
        ticks(3 * RSTC);
        rd(3'd0, v); check("R3 no reset rearm while held", v[0], 0);
        line_state = 2'b10;
        tick();
        line_state = 2'b00;
        ticks(RSTC);
        rd(3'd0, v); check("R3 brst rearmed", v[0], 1);
        line_state = 2'b10;
        wr(3'd0, 8'h01);

        // R4 any error flag
        err_flags = 8'h40;
        tick();
        err_flags = '0;
        rd(3'd0, v); check("R4 err set", v, 8'h02);
        wr(3'd0, 8'h02);

        // R5 device and host start-of-frame
        sof_rx = 1'b1; tick(); sof_rx = 1'b0;
        rd(3'd0, v); check("R5 dev sof", v[2], 1);
        wr(3'd0, 8'h04);
        wr(3'd3, 8'd3);
        frame_remain = 14'd3;
        tick();
        rd(3'd0, v); check("R5 no host sof in device", v[2], 0);
        frame_remain = 14'd10;
        host_mode = 1'b1;
        tick();
        rd(3'd0, v); check("R5 host above thr", v[2], 0);
        frame_remain = 14'd3;
        tick();
        rd(3'd0, v); check("R5 host at thr", v[2], 1);
        wr(3'd0, 8'h04);
        tick();
        rd(3'd0, v); check("R5 host once", v[2], 0);
        host_mode = 1'b0;
        frame_remain = 14'd0;

        // R6 pulse sources, R7 set wins and zero write
        stall_evt = 1'b1; attach_evt = 1'b1; resume_evt = 1'b1;
        tick();
        stall_evt = 1'b0; attach_evt = 1'b0; resume_evt = 1'b0;
        rd(3'd0, v); check("R6 pulse bits", v, 8'hE0);
        stall_evt = 1'b1;
        wr(3'd0, 8'h80);
        stall_evt = 1'b0;
        rd(3'd0, v); check("R7 set wins", v, 8'hE0);
        wr(3'd0, 8'h00);
        rd(3'd0, v); check("R7 zero write", v, 8'hE0);
        wr(3'd0, 8'hE0);
        rd(3'd0, v); check("R7 w1c", v, 8'h00);

        // R8 token slot, R9 overflow
        tok_in = 8'h11; tok_done = 1'b1; tick();
        tok_in = 8'h22; tick();
        tok_in = 8'h33; tick();
        tok_done = 1'b0;
        rd(3'd2, v); check("R8 first token", v, 8'h11);
        rd(3'd0, v); check("R8 flag set", v[3], 1);
        rd(3'd4, v); check("R9 overflow set", v, 1);
        wr(3'd0, 8'h08);
        rd(3'd2, v); check("R8 held promoted", v, 8'h22);
        rd(3'd0, v); check("R8 flag kept", v[3], 1);
        wr(3'd0, 8'h08);
        rd(3'd2, v); check("R9 dropped token cleared", v, 8'h00);
        rd(3'd0, v); check("R8 flag cleared", v[3], 0);
        rd(3'd4, v); check("R9 overflow sticky", v, 1);
        wr(3'd4, 8'h01);
        rd(3'd4, v); check("R9 overflow cleared", v, 0);

        // R10 enable gating
        wr(3'd1, 8'h20);
        check("R10 irq quiet", irq, 0);
        resume_evt = 1'b1; tick(); resume_evt = 1'b0;
        check("R10 irq raised", irq, 1);
        wr(3'd1, 8'hDF);
        check("R10 irq masked", irq, 0);
        wr(3'd1, 8'h20);
        check("R10 irq unmasked", irq, 1);
        wr(3'd0, 8'h20);
        check("R10 irq after clear", irq, 0);

        // Random phase: R4 R6 R7 R10 against a model
        rd(3'd1, m_en);
        m_stat = 8'h00;
        for (int it = 0; it < 3000; it++) begin
            logic [31:0] r;
            r = $urandom;
            stall_evt  = r[0] & r[1];
            attach_evt = r[2] & r[3];
            resume_evt = r[4] & r[5];
            sof_rx     = r[14] & r[15];
            err_flags  = (r[8:6] == 3'd0) ? ERR_W'(1) << r[11:9] : '0;
            reg_wr     = r[12];
            reg_addr   = r[13] ? 3'd1 : 3'd0;
            reg_wdata  = 8'($urandom) & 8'hF7;
            set = {stall_evt, attach_evt, resume_evt, 2'b00, sof_rx, |err_flags, 1'b0};
            clr = (reg_wr && reg_addr == 3'd0) ? reg_wdata : 8'h00;
            m_stat = next_stat(m_stat, clr, set);
            if (reg_wr && reg_addr == 3'd1) m_en = reg_wdata;
            tick();
            reg_wr = 1'b0;
            stall_evt = 1'b0; attach_evt = 1'b0; resume_evt = 1'b0;
            sof_rx = 1'b0; err_flags = '0;
            rd(3'd0, v);
            check("R7 random status", v, m_stat);
            check("R10 random irq", irq, |(m_stat & m_en));
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule